// File: doc/BRIEF.md
# Per-Window Configuration Bank with Frame-Boundary Commit

This block stores the configuration words of a set of overlay windows in a display pipeline. Each window owns a small group of configuration words, and every word exists twice: a staged copy that the register port writes and reads back, and a live copy that drives the display datapath. The live copies change only on a frame boundary, which is signalled by a one-cycle vertical sync strobe. Because of this, a change never takes effect partway through a frame.

A shared control word holds one hold-off bit and one channel-enable bit per window, plus a global output enable that has an immediate bit and a frame-synchronised bit. When software sets a window's hold-off bit, the frame boundary skips that window. Software can then rewrite several of the window's words. It commits them by setting the channel enable and clearing the hold-off bit in one control write. The new values reach the live copy at the next frame boundary. The live copies of every window are also brought out as a status output, so that checks can see them.

Top module: `win_shadow_bank`

## Requirements
- R1: After reset, every staged word, every live word, the control word, every live channel enable and `video_on` are zero.
- R2: A write to address w*NREG+r (window w, word r, for addresses below NWIN*NREG) updates the staged word, which reads back on `rd_data` in the same cycle that `rd_addr` selects it.
- R3: A live word never changes in a cycle without `vsync`. This holds for live words that have a pending staged write.
- R4: On a `vsync` cycle, every window whose hold-off bit (control bit w) is 0 copies all its staged words into its live words. The new values appear on `act_cfg` after that clock edge. Word r of window w sits at bits (w*NREG+r)*DW upward.
- R5: On a `vsync` cycle, a window whose hold-off bit is 1 keeps all its live words unchanged.
- R6: Windows are independent. A held-off window does not stop an unheld window from loading at the same `vsync`.
- R7: A single control write that clears hold-off and sets the channel enable makes no immediate change to the live words or to the live channel enables. The pending values load at the next `vsync`.
- R8: The live channel enable of window w (`act_chan_en[w]`) copies control bit NWIN+w at a `vsync` where the window is not held off. It keeps its value when the window is held off.
- R9: `video_on` can become 1 only at a `vsync`. It does so when both the immediate enable (control bit 2*NWIN) and the frame-synchronised enable (control bit 2*NWIN+1) are 1 at that edge.
- R10: Clearing the immediate enable turns `video_on` off by the second clock edge after the write, without waiting for a `vsync`.
- R11: Writes to addresses above NWIN*NREG are ignored, and reads there return zero. Address NWIN*NREG is the control word, which reads back zero-extended.
- R12: When a write and `vsync` occur in the same cycle, the live copy takes the previously staged value. The newly written value loads at the following `vsync`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write address (window words, then control word) |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Staged copy of the addressed word, zero for unused addresses |
| vsync | input | 1 | One-cycle frame boundary strobe |
| act_cfg | output | NWIN*NREG*DW | Live configuration words of all windows |
| act_chan_en | output | NWIN | Live channel enable per window |
| video_on | output | 1 | Global output enable as seen by the display |

## Verification
The bench uses the default parameters: five windows of four 32-bit words, which gives a 5-bit address with the control word at 20. With these values the lowest and highest window and word positions can be reached, and so can the control word boundary. Addresses 21 to 31 are also reachable, which lets the bench check that writes to them are ignored. The control field positions the bench relies on (hold-off in bits 0-4, channel enables in bits 5-9, enables in bits 10 and 11) follow from NWIN=5.

// File: rtl/win_shadow_pkg.sv
package win_shadow_pkg;
  // Control word layout: hold-off bits, channel enables, immediate enable, frame-sync enable.
  function automatic int hold_bit(input int w);
    return w;
  endfunction

  function automatic int chan_bit(input int nwin, input int w);
    return nwin + w;
  endfunction

  function automatic int ven_bit(input int nwin);
    return 2 * nwin;
  endfunction

  function automatic int ven_f_bit(input int nwin);
    return 2 * nwin + 1;
  endfunction
endpackage

// File: rtl/win_shadow_slot.sv
module win_shadow_slot #(
  parameter int NREG = 4,
  parameter int DW   = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NREG-1:0]      reg_we,
  input  logic [DW-1:0]        wdata,
  input  logic                 load,
  input  logic                 chan_wr,
  output logic [NREG*DW-1:0]   wr_flat,
  output logic [NREG*DW-1:0]   act_flat,
  output logic                 act_chan
);
  logic [NREG-1:0][DW-1:0] wr_q, wr_d;
  logic [NREG-1:0][DW-1:0] act_q, act_d;
  logic                    chan_q, chan_d;

  // Next state: staged words take writes, live words take staged at load.
  always_comb begin
    for (int r = 0; r < NREG; r++) begin
      wr_d[r] = reg_we[r] ? wdata : wr_q[r];
    end
    act_d  = load ? wr_q : act_q;
    chan_d = load ? chan_wr : chan_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      act_q  <= '0;
      chan_q <= 1'b0;
    end else begin
      wr_q   <= wr_d;
      act_q  <= act_d;
      chan_q <= chan_d;
    end
  end

  assign wr_flat  = wr_q;
  assign act_flat = act_q;
  assign act_chan = chan_q;
endmodule

// File: rtl/win_shadow_ctl.sv
module win_shadow_ctl import win_shadow_pkg::*; #(
  parameter int NWIN = 5,
  localparam int CW  = 2 * NWIN + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [CW-1:0] wdata,
  input  logic          vsync,
  output logic [CW-1:0] ctl_q,
  output logic          video_on
);
  logic [CW-1:0] ctl_d;
  logic          von_q, von_d;
  logic          en_now, en_sync;

  assign en_now  = ctl_q[ven_bit(NWIN)];
  assign en_sync = ctl_q[ven_f_bit(NWIN)];

  // Output may start only on a frame boundary, but stops as soon as the
  // immediate enable is gone.
  always_comb begin
    ctl_d = we ? wdata : ctl_q;
    if (vsync) von_d = en_now & en_sync;
    else       von_d = von_q & en_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      von_q <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      von_q <= von_d;
    end
  end

  assign video_on = von_q;
endmodule

// File: rtl/win_shadow_bank.sv
module win_shadow_bank import win_shadow_pkg::*; #(
  parameter int NWIN = 5,
  parameter int NREG = 4,
  parameter int DW   = 32,
  localparam int NCFG = NWIN * NREG,
  localparam int AW   = $clog2(NCFG + 1),
  localparam int CW   = 2 * NWIN + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [AW-1:0]            wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic [AW-1:0]            rd_addr,
  output logic [DW-1:0]            rd_data,
  input  logic                     vsync,
  output logic [NCFG*DW-1:0]       act_cfg,
  output logic [NWIN-1:0]          act_chan_en,
  output logic                     video_on
);
  logic [NCFG-1:0]    cfg_we;
  logic               ctl_we;
  logic [CW-1:0]      ctl_q;
  logic [NCFG*DW-1:0] wr_flat;

  // Write decode
  always_comb begin
    cfg_we = '0;
    if (wr_en && (wr_addr < AW'(NCFG))) cfg_we[wr_addr] = 1'b1;
  end
  assign ctl_we = wr_en && (wr_addr == AW'(NCFG));

  win_shadow_ctl #(.NWIN(NWIN)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (ctl_we),
    .wdata    (wr_data[CW-1:0]),
    .vsync    (vsync),
    .ctl_q    (ctl_q),
    .video_on (video_on)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    win_shadow_slot #(.NREG(NREG), .DW(DW)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_we   (cfg_we[w*NREG +: NREG]),
      .wdata    (wr_data),
      .load     (vsync & ~ctl_q[hold_bit(w)]),
      .chan_wr  (ctl_q[chan_bit(NWIN, w)]),
      .wr_flat  (wr_flat[w*NREG*DW +: NREG*DW]),
      .act_flat (act_cfg[w*NREG*DW +: NREG*DW]),
      .act_chan (act_chan_en[w])
    );
  end

  // Read mux returns the staged copy
  always_comb begin
    rd_data = '0;
    if (rd_addr < AW'(NCFG))       rd_data = wr_flat[int'(rd_addr)*DW +: DW];
    else if (rd_addr == AW'(NCFG)) rd_data = DW'(ctl_q);
  end
endmodule

// File: rtl/win_shadow_bank_chk.sv
module win_shadow_bank_chk #(
  parameter int NWIN = 5,
  parameter int NREG = 4,
  parameter int DW   = 32,
  localparam int NCFG = NWIN * NREG,
  localparam int AW   = $clog2(NCFG + 1),
  localparam int CW   = 2 * NWIN + 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               vsync,
  input logic [CW-1:0]      ctl_q,
  input logic [NCFG*DW-1:0] wr_flat,
  input logic [NCFG*DW-1:0] act_cfg,
  input logic [NWIN-1:0]    act_chan_en,
  input logic               video_on,
  input logic [AW-1:0]      rd_addr,
  input logic [DW-1:0]      rd_data
);
  AST_HOLD_NO_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync |=> $stable(act_cfg)); // R3

  AST_VIDEO_RISE_AT_VSYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(video_on) |-> $past(vsync)); // R9

  AST_READ_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr > AW'(NCFG)) |-> (rd_data == '0)); // R11

  for (genvar w = 0; w < NWIN; w++) begin : g_chk
    AST_HELD_WINDOW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync && ctl_q[w]) |=> $stable(act_cfg[w*NREG*DW +: NREG*DW])); // R5

    AST_FREE_WINDOW_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync && !ctl_q[w]) |=>
        (act_cfg[w*NREG*DW +: NREG*DW] == $past(wr_flat[w*NREG*DW +: NREG*DW]))); // R4

    AST_HELD_CHAN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync && ctl_q[w]) |=> $stable(act_chan_en[w])); // R8
  end
endmodule

bind win_shadow_bank win_shadow_bank_chk #(.NWIN(NWIN), .NREG(NREG), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .vsync       (vsync),
  .ctl_q       (ctl_q),
  .wr_flat     (wr_flat),
  .act_cfg     (act_cfg),
  .act_chan_en (act_chan_en),
  .video_on    (video_on),
  .rd_addr     (rd_addr),
  .rd_data     (rd_data)
);

// File: tb/win_shadow_bank_bench.sv
`timescale 1ns/1ps
module win_shadow_bank_bench;
  localparam int NWIN = 5;
  localparam int NREG = 4;
  localparam int DW   = 32;
  localparam int AW   = 5;
  localparam int CTLA = 20;

  logic                      clk = 1'b0;
  logic                      rst_n;
  logic                      wr_en;
  logic [AW-1:0]             wr_addr;
  logic [DW-1:0]             wr_data;
  logic [AW-1:0]             rd_addr;
  logic [DW-1:0]             rd_data;
  logic                      vsync;
  logic [NWIN*NREG*DW-1:0]   act_cfg;
  logic [NWIN-1:0]           act_chan_en;
  logic                      video_on;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  win_shadow_bank #(.NWIN(NWIN), .NREG(NREG), .DW(DW)) u_win_shadow_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .vsync(vsync), .act_cfg(act_cfg),
    .act_chan_en(act_chan_en), .video_on(video_on)
  );

  function automatic logic [DW-1:0] live(input int w, input int r);
    return act_cfg[(w*NREG+r)*DW +: DW];
  endfunction

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Drive at a falling edge; the rising edge between captures the cycle.
  task automatic cycle(input logic we, input int a, input logic [DW-1:0] d, input logic vs);
    @(negedge clk);
    wr_en = we; wr_addr = AW'(a); wr_data = d; vsync = vs;
    @(negedge clk);
    wr_en = 1'b0; vsync = 1'b0;
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    cycle(1'b1, a, d, 1'b0);
  endtask

  task automatic frame();
    cycle(1'b0, 0, '0, 1'b1);
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    rd_addr = AW'(a);
    #1 d = rd_data;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    check("R1 live words zero", DW'(act_cfg != '0), '0);
    check("R1 chan enables zero", DW'(act_chan_en), '0);
    check("R1 video_on zero", DW'(video_on), '0);
    rd(CTLA, v); check("R1 control zero", v, '0);
    rd(9, v);    check("R1 staged zero", v, '0);
  endtask

  task automatic t_write_read();
    logic [DW-1:0] v;
    wr(9, 32'hA5A5_0009);
    wr(19, 32'h0000_1313);
    rd(9, v);  check("R2 readback w2r1", v, 32'hA5A5_0009);
    rd(19, v); check("R2 readback w4r3", v, 32'h0000_1313);
    check("R3 live unchanged w2r1", live(2, 1), '0);
    check("R3 live unchanged w4r3", live(4, 3), '0);
  endtask

  task automatic t_frame_load();
    frame();
    check("R4 load w2r1", live(2, 1), 32'hA5A5_0009);
    check("R4 load w4r3", live(4, 3), 32'h0000_1313);
  endtask

  task automatic t_hold();
    wr(CTLA, 32'h0000_0002);          // hold window 1
    wr(4, 32'h1111_0004);
    wr(14, 32'h3333_000E);
    frame();
    check("R5 held w1r0", live(1, 0), '0);
    check("R6 free w3r2 loads", live(3, 2), 32'h3333_000E);
  endtask

  task automatic t_release();
    wr(CTLA, 32'h0000_0040);          // chan 1 on, hold cleared
    check("R7 no immediate load", live(1, 0), '0);
    check("R7 no immediate chan", DW'(act_chan_en), '0);
    frame();
    check("R7 load next vsync", live(1, 0), 32'h1111_0004);
    check("R8 chan live", DW'(act_chan_en), 32'h2);
    wr(CTLA, 32'h0000_0002);          // held, chan bit cleared
    frame();
    check("R8 held chan kept", DW'(act_chan_en), 32'h2);
    wr(CTLA, 32'h0);
    frame();
    check("R8 chan cleared", DW'(act_chan_en), 32'h0);
  endtask

  task automatic t_video();
    wr(CTLA, 32'h0000_0C00);
    check("R9 off before vsync", DW'(video_on), 32'h0);
    @(negedge clk);
    check("R9 still off", DW'(video_on), 32'h0);
    frame();
    check("R9 on at vsync", DW'(video_on), 32'h1);
    wr(CTLA, 32'h0000_0800);          // immediate enable cleared
    @(negedge clk);
    check("R10 off without vsync", DW'(video_on), 32'h0);
    wr(CTLA, 32'h0000_0C00);
    repeat (3) @(negedge clk);
    check("R9 no restart without vsync", DW'(video_on), 32'h0);
  endtask

  task automatic t_range();
    logic [DW-1:0] v;
    wr(25, 32'hFFFF_FFFF);
    wr(31, 32'hFFFF_FFFF);
    rd(25, v);   check("R11 read zero 25", v, '0);
    rd(31, v);   check("R11 read zero 31", v, '0);
    rd(CTLA, v); check("R11 control intact", v, 32'h0000_0C00);
    rd(9, v);    check("R11 window intact", v, 32'hA5A5_0009);
    wr(CTLA, 32'h0);
  endtask

  task automatic t_same_cycle();
    logic [DW-1:0] v;
    wr(0, 32'h0000_AAAA);
    frame();
    check("R4 load w0r0", live(0, 0), 32'h0000_AAAA);
    cycle(1'b1, 0, 32'h0000_BBBB, 1'b1);
    check("R12 old staged value", live(0, 0), 32'h0000_AAAA);
    rd(0, v); check("R12 staged new", v, 32'h0000_BBBB);
    frame();
    check("R12 new at next vsync", live(0, 0), 32'h0000_BBBB);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0; vsync = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_frame_load();
    t_hold();
    t_release();
    t_video();
    t_range();
    t_same_cycle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule